// File: doc/BRIEF.md
# Region-of-Interest Crop Controller

This block sits in a raster pixel stream whose beats carry a valid flag and a start-of-frame flag. It works out the column and row of every valid input pixel and forwards only the pixels that fall inside a rectangular window. The window is set by an origin and an extent on each axis. The block also raises a fresh start-of-frame flag on the first forwarded pixel, which is the window's upper-left corner.

Window settings arrive through a plain write port. Each write lands in a shadow copy. The shadow copy is range-clamped and moved into the working copy only on the valid beat that opens a new frame. Changing the settings in the middle of a frame therefore never mixes two windows in one frame. A mode bit can force the window to cover the whole frame without disturbing the stored origin and extent.

Top module: `roi_crop`

## Requirements
- R1: After reset, `pix_valid_o` and `pix_sof_o` are 0. The working window covers the whole frame: origin (0,0), extent FRAME_W x FRAME_H.
- R2: A forwarded pixel appears on `pix_valid_o`/`pix_data_o` exactly one clock after its input beat, with the same data.
- R3: An input beat is forwarded only if its column is in [x, x+w-1] and its row is in [y, y+h-1]. In every other cycle `pix_valid_o` is 0.
- R4: `pix_sof_o` is 1 only together with the forwarded pixel at column x, row y. It is 0 for every other output pixel.
- R5: Position advances only on beats with `pix_valid_i`=1. The column counts 0..FRAME_W-1, then wraps to 0 and the row increments. Idle cycles do not move the position.
- R6: A beat with `pix_valid_i`=1 and `pix_sof_i`=1 is at column 0, row 0, whatever position came before it.
- R7: Writes go to a shadow copy. The shadow copy becomes the working window only on a beat with `pix_valid_i`=1 and `pix_sof_i`=1, and that beat already uses it. A write made during a frame has no effect until the next frame starts.
- R8: Write addresses: 0 = origin x, 1 = origin y, 2 = width, 3 = height, 4 = mode (bit 0 set = whole frame). Writes to addresses 5..7 change nothing.
- R9: On commit, the origin is clamped to at most FRAME_W-1 (or FRAME_H-1). A zero extent becomes 1. An extent larger than FRAME_W-x (or FRAME_H-y) is cut down to that value.
- R10: While mode bit 0 is set, the committed window is (0,0) with extent FRAME_W x FRAME_H. Clearing the bit restores the stored origin and extent at the next frame start.
- R11: `pix_sof_i`=1 with `pix_valid_i`=0 is ignored. It neither resets the position nor commits the shadow copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_valid_i | input | 1 | Input beat valid |
| pix_sof_i | input | 1 | Input beat is the first pixel of a frame |
| pix_data_i | input | DATA_W | Input pixel |
| cfg_wr_i | input | 1 | Window setting write strobe |
| cfg_addr_i | input | 3 | Window setting address |
| cfg_wdata_i | input | CFG_W | Window setting write value |
| pix_valid_o | output | 1 | Output beat valid |
| pix_sof_o | output | 1 | Output beat is the window's upper-left pixel |
| pix_data_o | output | DATA_W | Output pixel |

## Verification
Every forwarded pixel, and its start-of-frame flag, is due one clock after its input beat. The bench drives inputs on falling edges and samples outputs on the following falling edge, so each output is read half a cycle after the edge that produced it. A frame's results are checked only after two more falling edges, so the last beat has landed. A window write is expected to show up at the first start-of-frame beat after it, never sooner. The bench therefore computes each frame's expected window when the frame starts, and applies writes made during the frame only to the next one.

// File: rtl/roi_crop_pkg.sv
package roi_crop_pkg;

  localparam int CFG_ADDR_W = 3;

  typedef enum logic [CFG_ADDR_W-1:0] {
    REG_ORG_X = 3'd0,
    REG_ORG_Y = 3'd1,
    REG_EXT_W = 3'd2,
    REG_EXT_H = 3'd3,
    REG_MODE  = 3'd4
  } roi_reg_e;

  localparam int AXIS_X = 0;
  localparam int AXIS_Y = 1;
  localparam int N_AXES = 2;

endpackage

// File: rtl/roi_rst_sync.sv
module roi_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/roi_axis_clamp.sv
module roi_axis_clamp #(
  parameter int SPAN  = 64,
  parameter int CFG_W = 16,
  parameter int PW    = 7
) (
  input  logic [CFG_W-1:0] raw_org_i,
  input  logic [CFG_W-1:0] raw_ext_i,
  input  logic             full_i,
  output logic [PW-1:0]    org_o,
  output logic [PW-1:0]    ext_o
);

  localparam int WW = ((CFG_W > PW) ? CFG_W : PW) + 1;
  localparam logic [WW-1:0] SPAN_W = WW'(SPAN);
  localparam logic [WW-1:0] LAST_W = WW'(SPAN - 1);

  logic [WW-1:0] org_w;
  logic [WW-1:0] room_w;
  logic [WW-1:0] ext_w;

  // Origin first, then extent limited by the room left after the origin.
  always_comb begin
    org_w = WW'(raw_org_i);
    if (org_w > LAST_W) org_w = LAST_W;
    room_w = SPAN_W - org_w;
    ext_w  = WW'(raw_ext_i);
    if (ext_w == '0)          ext_w = WW'(1);
    else if (ext_w > room_w)  ext_w = room_w;
    if (full_i) begin
      org_o = '0;
      ext_o = PW'(SPAN);
    end else begin
      org_o = org_w[PW-1:0];
      ext_o = ext_w[PW-1:0];
    end
  end

endmodule

// File: rtl/roi_region_regs.sv
module roi_region_regs
  import roi_crop_pkg::*;
#(
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 48,
  parameter int CFG_W   = 16,
  parameter int PW      = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_wr_i,
  input  logic [CFG_ADDR_W-1:0]          cfg_addr_i,
  input  logic [CFG_W-1:0]               cfg_wdata_i,
  input  logic                           commit_i,
  output logic [N_AXES-1:0][PW-1:0]      act_org_o,
  output logic [N_AXES-1:0][PW-1:0]      act_ext_o,
  output logic [N_AXES-1:0][PW-1:0]      cand_org_o,
  output logic [N_AXES-1:0][PW-1:0]      cand_ext_o
);

  logic [N_AXES-1:0][CFG_W-1:0] shd_org_q, shd_org_d;
  logic [N_AXES-1:0][CFG_W-1:0] shd_ext_q, shd_ext_d;
  logic                         shd_full_q, shd_full_d;
  logic [N_AXES-1:0][PW-1:0]    act_org_q, act_org_d;
  logic [N_AXES-1:0][PW-1:0]    act_ext_q, act_ext_d;

  // Shadow write decode
  always_comb begin
    shd_org_d  = shd_org_q;
    shd_ext_d  = shd_ext_q;
    shd_full_d = shd_full_q;
    if (cfg_wr_i) begin
      case (roi_reg_e'(cfg_addr_i))
        REG_ORG_X: shd_org_d[AXIS_X] = cfg_wdata_i;
        REG_ORG_Y: shd_org_d[AXIS_Y] = cfg_wdata_i;
        REG_EXT_W: shd_ext_d[AXIS_X] = cfg_wdata_i;
        REG_EXT_H: shd_ext_d[AXIS_Y] = cfg_wdata_i;
        REG_MODE:  shd_full_d        = cfg_wdata_i[0];
        default:   ;
      endcase
    end
  end

  // Clamp each axis of the shadow copy against its own frame span
  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    localparam int SPAN = (a == AXIS_X) ? FRAME_W : FRAME_H;
    roi_axis_clamp #(
      .SPAN  (SPAN),
      .CFG_W (CFG_W),
      .PW    (PW)
    ) clamp_i (
      .raw_org_i (shd_org_q[a]),
      .raw_ext_i (shd_ext_q[a]),
      .full_i    (shd_full_q),
      .org_o     (cand_org_o[a]),
      .ext_o     (cand_ext_o[a])
    );
  end

  // Working copy follows the clamped shadow only at frame start
  always_comb begin
    act_org_d = act_org_q;
    act_ext_d = act_ext_q;
    if (commit_i) begin
      act_org_d = cand_org_o;
      act_ext_d = cand_ext_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_org_q          <= '0;
      shd_ext_q[AXIS_X]  <= CFG_W'(FRAME_W);
      shd_ext_q[AXIS_Y]  <= CFG_W'(FRAME_H);
      shd_full_q         <= 1'b0;
      act_org_q          <= '0;
      act_ext_q[AXIS_X]  <= PW'(FRAME_W);
      act_ext_q[AXIS_Y]  <= PW'(FRAME_H);
    end else begin
      shd_org_q  <= shd_org_d;
      shd_ext_q  <= shd_ext_d;
      shd_full_q <= shd_full_d;
      act_org_q  <= act_org_d;
      act_ext_q  <= act_ext_d;
    end
  end

  assign act_org_o = act_org_q;
  assign act_ext_o = act_ext_q;

endmodule

// File: rtl/roi_raster_pos.sv
module roi_raster_pos #(
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 48,
  parameter int PW      = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_i,
  input  logic          start_i,
  output logic [PW-1:0] col_o,
  output logic [PW-1:0] row_o
);

  localparam logic [PW-1:0] COL_LAST = PW'(FRAME_W - 1);
  localparam logic [PW-1:0] ROW_LAST = PW'(FRAME_H - 1);

  logic [PW-1:0] col_q, col_d;
  logic [PW-1:0] row_q, row_d;

  always_comb begin
    col_o = start_i ? '0 : col_q;
    row_o = start_i ? '0 : row_q;
    col_d = col_q;
    row_d = row_q;
    if (beat_i) begin
      if (col_o == COL_LAST) begin
        col_d = '0;
        row_d = (row_o == ROW_LAST) ? '0 : row_o + 1'b1;
      end else begin
        col_d = col_o + 1'b1;
        row_d = row_o;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

endmodule

// File: rtl/roi_out_gate.sv
module roi_out_gate #(
  parameter int DATA_W = 8,
  parameter int PW     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PW-1:0]     col_i,
  input  logic [PW-1:0]     row_i,
  input  logic [PW-1:0]     org_x_i,
  input  logic [PW-1:0]     org_y_i,
  input  logic [PW-1:0]     ext_w_i,
  input  logic [PW-1:0]     ext_h_i,
  output logic              valid_o,
  output logic              sof_o,
  output logic [DATA_W-1:0] data_o
);

  logic in_x, in_y, hit, corner;
  logic valid_d, sof_d;
  logic valid_q, sof_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    in_x    = (col_i >= org_x_i) && ((col_i - org_x_i) < ext_w_i);
    in_y    = (row_i >= org_y_i) && ((row_i - org_y_i) < ext_h_i);
    hit     = beat_i && in_x && in_y;
    corner  = (col_i == org_x_i) && (row_i == org_y_i);
    valid_d = hit;
    sof_d   = hit && corner;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sof_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      sof_q   <= sof_d;
    end
  end

  // Datapath register: no reset, loads only on a forwarded beat
  always_ff @(posedge clk) begin
    if (hit) data_q <= data_i;
  end

  assign valid_o = valid_q;
  assign sof_o   = sof_q;
  assign data_o  = data_q;

endmodule

// File: rtl/roi_crop.sv
module roi_crop
  import roi_crop_pkg::*;
#(
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 48,
  parameter int DATA_W  = 8,
  parameter int CFG_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pix_valid_i,
  input  logic                  pix_sof_i,
  input  logic [DATA_W-1:0]     pix_data_i,
  input  logic                  cfg_wr_i,
  input  logic [CFG_ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]      cfg_wdata_i,
  output logic                  pix_valid_o,
  output logic                  pix_sof_o,
  output logic [DATA_W-1:0]     pix_data_o
);

  localparam int MAX_SPAN = (FRAME_W > FRAME_H) ? FRAME_W : FRAME_H;
  localparam int PW       = $clog2(MAX_SPAN + 1);

  logic                      rst_sync_n;
  logic                      frame_start;
  logic [N_AXES-1:0][PW-1:0] act_org, act_ext, cand_org, cand_ext;
  logic [N_AXES-1:0][PW-1:0] sel_org, sel_ext;
  logic [PW-1:0]             cur_col, cur_row;

  roi_rst_sync rst_sync_i (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  assign frame_start = pix_valid_i && pix_sof_i;

  roi_region_regs #(
    .FRAME_W (FRAME_W),
    .FRAME_H (FRAME_H),
    .CFG_W   (CFG_W),
    .PW      (PW)
  ) regs_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .commit_i    (frame_start),
    .act_org_o   (act_org),
    .act_ext_o   (act_ext),
    .cand_org_o  (cand_org),
    .cand_ext_o  (cand_ext)
  );

  // The opening beat of a frame already uses the newly committed window
  assign sel_org = frame_start ? cand_org : act_org;
  assign sel_ext = frame_start ? cand_ext : act_ext;

  roi_raster_pos #(
    .FRAME_W (FRAME_W),
    .FRAME_H (FRAME_H),
    .PW      (PW)
  ) pos_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .beat_i  (pix_valid_i),
    .start_i (frame_start),
    .col_o   (cur_col),
    .row_o   (cur_row)
  );

  roi_out_gate #(
    .DATA_W (DATA_W),
    .PW     (PW)
  ) gate_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .beat_i  (pix_valid_i),
    .data_i  (pix_data_i),
    .col_i   (cur_col),
    .row_i   (cur_row),
    .org_x_i (sel_org[AXIS_X]),
    .org_y_i (sel_org[AXIS_Y]),
    .ext_w_i (sel_ext[AXIS_X]),
    .ext_h_i (sel_ext[AXIS_Y]),
    .valid_o (pix_valid_o),
    .sof_o   (pix_sof_o),
    .data_o  (pix_data_o)
  );

endmodule

// File: rtl/roi_crop_chk.sv
module roi_crop_chk #(
  parameter int FRAME_W = 64,
  parameter int FRAME_H = 48,
  parameter int DATA_W  = 8,
  parameter int PW      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid_i,
  input logic              pix_sof_i,
  input logic [DATA_W-1:0] pix_data_i,
  input logic              pix_valid_o,
  input logic              pix_sof_o,
  input logic [DATA_W-1:0] pix_data_o,
  input logic [PW-1:0]     act_x,
  input logic [PW-1:0]     act_y,
  input logic [PW-1:0]     act_w,
  input logic [PW-1:0]     act_h
);

  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> $past(pix_valid_i)); // R2

  AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> (pix_data_o == $past(pix_data_i))); // R2

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid_i |=> !pix_valid_o); // R3

  AST_SOF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sof_o |-> pix_valid_o); // R4

  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid_i && pix_sof_i) |=> ($stable(act_x) && $stable(act_y) && $stable(act_w) && $stable(act_h))); // R7

  AST_CLAMP_X: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(act_x) + 32'(act_w)) <= FRAME_W) && (act_w != '0)); // R9

  AST_CLAMP_Y: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(act_y) + 32'(act_h)) <= FRAME_H) && (act_h != '0)); // R9

endmodule

bind roi_crop roi_crop_chk #(
  .FRAME_W (FRAME_W),
  .FRAME_H (FRAME_H),
  .DATA_W  (DATA_W),
  .PW      (PW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .pix_valid_i (pix_valid_i),
  .pix_sof_i   (pix_sof_i),
  .pix_data_i  (pix_data_i),
  .pix_valid_o (pix_valid_o),
  .pix_sof_o   (pix_sof_o),
  .pix_data_o  (pix_data_o),
  .act_x       (act_org[0]),
  .act_y       (act_org[1]),
  .act_w       (act_ext[0]),
  .act_h       (act_ext[1])
);

// File: tb/roi_crop_tb_top.sv
`timescale 1ns/1ps
module roi_crop_tb_top;

  localparam int TW = 12;
  localparam int TH = 8;
  localparam int DW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pix_valid_i, pix_sof_i;
  logic [DW-1:0] pix_data_i;
  logic          cfg_wr_i;
  logic [2:0]    cfg_addr_i;
  logic [CW-1:0] cfg_wdata_i;
  logic          pix_valid_o, pix_sof_o;
  logic [DW-1:0] pix_data_o;

  int vectors = 0;
  int miscompares = 0;

  // bench model of the shadow settings
  int m_org[2];
  int m_ext[2];
  int m_full;

  int cap_data[4096];
  int cap_sof[4096];
  int cap_n = 0;

  always #5 clk = ~clk;

  roi_crop #(.FRAME_W(TW), .FRAME_H(TH), .DATA_W(DW), .CFG_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pix_valid_i(pix_valid_i), .pix_sof_i(pix_sof_i), .pix_data_i(pix_data_i),
    .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .pix_valid_o(pix_valid_o), .pix_sof_o(pix_sof_o), .pix_data_o(pix_data_o)
  );

  always @(negedge clk) begin
    if (pix_valid_o === 1'b1 && cap_n < 4096) begin
      cap_data[cap_n] = int'(pix_data_o);
      cap_sof[cap_n]  = int'(pix_sof_o);
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected working window from the requirements (R9, R10)
  task automatic exp_region(output int ex, output int ey, output int ew, output int eh);
    int span[2];
    int o[2];
    int e[2];
    span[0] = TW; span[1] = TH;
    for (int a = 0; a < 2; a++) begin
      if (m_full != 0) begin
        o[a] = 0; e[a] = span[a];
      end else begin
        o[a] = (m_org[a] > span[a] - 1) ? span[a] - 1 : m_org[a];
        e[a] = m_ext[a];
        if (e[a] == 0) e[a] = 1;
        else if (e[a] > span[a] - o[a]) e[a] = span[a] - o[a];
      end
    end
    ex = o[0]; ey = o[1]; ew = e[0]; eh = e[1];
  endtask

  task automatic model_write(input int addr, input int data);
    case (addr)
      0: m_org[0] = data;
      1: m_org[1] = data;
      2: m_ext[0] = data;
      3: m_ext[1] = data;
      4: m_full   = data & 1;
      default: ;
    endcase
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_wr_i = 1'b1; cfg_addr_i = 3'(addr); cfg_wdata_i = CW'(data);
    @(negedge clk);
    cfg_wr_i = 1'b0;
    model_write(addr, data);
  endtask

  // One full frame in raster order; optional idle gaps (with stray sof) and a mid-frame write
  task automatic run_frame(input int gap, input bit sof_gap, input bit mw_en,
                           input int mw_addr, input int mw_data, input string req);
    int ex, ey, ew, eh, base, n, pix, bad_i, bad_a, bad_e, sof_bad;
    exp_region(ex, ey, ew, eh);
    base = cap_n;
    pix = 0;
    for (int r = 0; r < TH; r++) begin
      for (int c = 0; c < TW; c++) begin
        @(negedge clk);
        pix_valid_i = 1'b1;
        pix_sof_i   = (r == 0 && c == 0);
        pix_data_i  = DW'(r * TW + c);
        if (mw_en && pix == 10) begin
          cfg_wr_i = 1'b1; cfg_addr_i = 3'(mw_addr); cfg_wdata_i = CW'(mw_data);
        end else cfg_wr_i = 1'b0;
        pix++;
        if (gap > 0 && pix % 3 == 0) begin
          for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            pix_valid_i = 1'b0; pix_sof_i = sof_gap; cfg_wr_i = 1'b0;
          end
        end
      end
    end
    @(negedge clk);
    pix_valid_i = 1'b0; pix_sof_i = 1'b0; cfg_wr_i = 1'b0;
    if (mw_en) model_write(mw_addr, mw_data);
    @(negedge clk);
    @(negedge clk);
    n = cap_n - base;
    chk(n == ew * eh, req, "forwarded pixel count", n, ew * eh);
    bad_i = -1; bad_a = 0; bad_e = 0; sof_bad = -1;
    for (int i = 0; i < n && i < ew * eh; i++) begin
      int e;
      e = (ey + i / ew) * TW + ex + i % ew;
      if (bad_i < 0 && cap_data[base + i] != e) begin
        bad_i = i; bad_a = cap_data[base + i]; bad_e = e;
      end
      if (sof_bad < 0 && cap_sof[base + i] != ((i == 0) ? 1 : 0)) sof_bad = i;
    end
    chk(bad_i < 0, req, "forwarded pixel value", bad_a, bad_e);
    chk(sof_bad < 0, {req, "/R4"}, "index of wrong sof flag", sof_bad, -1);
  endtask

  task automatic t_reset;
    chk(pix_valid_o == 1'b0, "R1", "valid after reset", int'(pix_valid_o), 0);
    chk(pix_sof_o == 1'b0, "R1", "sof after reset", int'(pix_sof_o), 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    pix_valid_i = 1'b1; pix_sof_i = 1'b1; pix_data_i = 8'hA5;
    @(negedge clk);
    pix_valid_i = 1'b0; pix_sof_i = 1'b1; pix_data_i = 8'h00;
    chk(pix_valid_o == 1'b1, "R2", "valid one cycle after beat", int'(pix_valid_o), 1);
    chk(pix_data_o == 8'hA5, "R2", "data one cycle after beat", int'(pix_data_o), 'hA5);
    chk(pix_sof_o == 1'b1, "R6", "sof at corner of reset window", int'(pix_sof_o), 1);
    @(negedge clk);
    pix_valid_i = 1'b1; pix_sof_i = 1'b0; pix_data_i = 8'h3C;
    chk(pix_valid_o == 1'b0, "R3", "valid on idle input", int'(pix_valid_o), 0);
    @(negedge clk);
    pix_valid_i = 1'b0;
    chk(pix_valid_o == 1'b1 && pix_data_o == 8'h3C, "R5", "second pixel forwarded", int'(pix_data_o), 'h3C);
    chk(pix_sof_o == 1'b0, "R11", "sof after sof-without-valid", int'(pix_sof_o), 0);
    @(negedge clk);
  endtask

  task automatic t_default_frame;
    run_frame(0, 1'b0, 1'b0, 0, 0, "R1");
  endtask

  task automatic t_window;
    cfg_write(0, 3); cfg_write(1, 2); cfg_write(2, 4); cfg_write(3, 3);
    run_frame(0, 1'b0, 1'b0, 0, 0, "R3/R8");
  endtask

  task automatic t_gaps;
    run_frame(2, 1'b1, 1'b0, 0, 0, "R5/R11");
  endtask

  task automatic t_midframe_write;
    run_frame(0, 1'b0, 1'b1, 0, 0, "R7");
    run_frame(1, 1'b0, 1'b0, 0, 0, "R7");
  endtask

  task automatic t_clamp;
    cfg_write(0, 200); cfg_write(2, 50); cfg_write(1, 1); cfg_write(3, 0);
    run_frame(0, 1'b0, 1'b0, 0, 0, "R9");
    cfg_write(0, 5); cfg_write(2, 20); cfg_write(1, 6); cfg_write(3, 9);
    run_frame(0, 1'b0, 1'b0, 0, 0, "R9");
  endtask

  task automatic t_full_mode;
    cfg_write(4, 1);
    run_frame(0, 1'b0, 1'b0, 0, 0, "R10");
    cfg_write(4, 0);
    run_frame(0, 1'b0, 1'b0, 0, 0, "R10");
  endtask

  task automatic t_bad_addr;
    cfg_write(6, 0); cfg_write(7, 0); cfg_write(5, 1);
    run_frame(0, 1'b0, 1'b0, 0, 0, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    m_org[0] = 0; m_org[1] = 0; m_ext[0] = TW; m_ext[1] = TH; m_full = 0;
    rst_n = 1'b0;
    pix_valid_i = 1'b0; pix_sof_i = 1'b0; pix_data_i = '0;
    cfg_wr_i = 1'b0; cfg_addr_i = '0; cfg_wdata_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_default_frame();
    t_window();
    t_gaps();
    t_midframe_write();
    t_clamp();
    t_full_mode();
    t_bad_addr();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule